// File: doc/BRIEF.md
# Periodic interrupt interval generator

This block turns a free-running real-time tick strobe into a periodic, sticky interrupt flag. The tick period is 16/3 µs, so 75 ticks make 400 µs. Software picks one of seven intervals, from 100 µs to 5 ms, through an 8-bit control register. Non-integer tick counts per interval are met exactly on average by alternating counts.

The pulse generator has two stages. The bottom stage cuts the tick stream into sub-pulses of 19, 19, 19 and 18 ticks, one sub-pulse per 100 µs. The top stage counts sub-pulses for the longer intervals. Disabling the block freezes both stages. Enabling it again resumes from the held position. A clear command, or a change of the interval select, restarts the sequence from its first sub-pulse.

Control register layout: bit 7 is the interrupt flag, bit 6 the enable, bit 5 a write-only restart command, bits 4:3 are unused, and bits 2:0 select the interval.

Top module: `rtc_interval_gen`

## Requirements
- R1: After reset the register reads 0x00 and both `irqFlag` and `irqReq` are 0.
- R2: Reading returns the flag in bit 7, the enable in bit 6 and the interval select in bits 2:0. Bits 5, 4 and 3 always read 0, and writes to bits 4:3 are ignored.
- R3: Select 1 (100 µs) raises an event after sub-pulses of 19, 19, 19 and 18 enabled ticks, repeating in that order.
- R4: Select 2 (200 µs) raises events after 38 and then 37 enabled ticks, alternating.
- R5: Select 3 gives an event every 75 ticks and select 4 every 150 ticks. Select 5 alternates 188 and 187 ticks, select 6 gives 375 ticks, and select 7 alternates 938 and 937 ticks. In general, the k-th event after a restart falls on tick ceil(k·U·75/4), where U is the interval in 100 µs units.
- R6: Select 0 never raises an event.
- R7: Once set, the flag stays 1 until a write with bit 7 equal to 0 arrives. Writing 1 to bit 7 leaves the flag unchanged.
- R8: When an event and a flag-clearing write happen in the same cycle, the flag stays 1.
- R9: While the enable is 0, ticks are ignored and the count is held. After re-enabling, counting continues from the held count.
- R10: A write with bit 5 set restarts the count from zero. Any tick in that cycle is dropped.
- R11: A write that changes bits 2:0 restarts the count. A write that keeps the same select does not.
- R12: `irqReq` is high for exactly the one cycle after the tick that completes an interval. The flag rises on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| tick | input | 1 | One-cycle real-time tick strobe |
| rdData | output | 8 | Register read data |
| irqFlag | output | 1 | Sticky interrupt flag |
| irqReq | output | 1 | One-cycle interval event pulse |

## Verification
The hardest case to reach from the ports is a flag-clearing write that lands on the exact tick that completes an interval. That write must keep the same select and leave bit 5 clear, otherwise the count restarts and no event occurs. The bench tracks its own count of enabled ticks since the last restart. It steps ticks until the next one is known to complete an interval, then issues the clearing write on that tick. The same model drives long constant-mode runs, so that the 938/937 alternation of the 5 ms mode is seen twice. Rare random writes then mix pauses, restarts and mode changes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic       restart;
    logic       advance;
    logic [2:0] divSel;
  } dpStrobe_t;

  // Interval length in sub-pulses for selects that use the top stage.
  function automatic int topTerm(input logic [2:0] sel, input int phases);
    case (sel)
      3'd3:    topTerm = phases;
      3'd4:    topTerm = 2 * phases;
      3'd5:    topTerm = 10;
      3'd6:    topTerm = 20;
      3'd7:    topTerm = 50;
      default: topTerm = 1;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       tick,
  input  logic       intervalHit,
  output dpStrobe_t  strobe,
  output logic       enReg,
  output logic [2:0] divReg,
  output logic       irqFlag,
  output logic       irqReq
);

  logic restartReq;

  assign restartReq     = wrEn && (wrData[5] || (wrData[2:0] != divReg));
  assign strobe.restart = restartReq;
  assign strobe.advance = tick && enReg && !restartReq;
  assign strobe.divSel  = divReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= 1'b0;
      divReg  <= 3'd0;
      irqFlag <= 1'b0;
      irqReq  <= 1'b0;
    end else begin
      irqReq <= intervalHit;
      if (wrEn) begin
        enReg  <= wrData[6];
        divReg <= wrData[2:0];
      end
      if (intervalHit)
        irqFlag <= 1'b1;
      else if (wrEn && !wrData[7])
        irqFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/rtc_pulse_dp.sv
module rtc_pulse_dp
  import rtc_pkg::*;
#(
  parameter int SUB_LONG   = 19,
  parameter int SUB_PHASES = 4,
  parameter int TOP_W      = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  output logic      intervalHit
);

  localparam int SUB_W = $clog2(SUB_LONG);
  localparam int IDX_W = (SUB_PHASES > 1) ? $clog2(SUB_PHASES) : 1;

  logic [SUB_W-1:0] subCount;
  logic [IDX_W-1:0] subIdx;
  logic [TOP_W-1:0] topCount;
  logic [SUB_W-1:0] subLimit;
  logic [TOP_W-1:0] topLimit;
  logic             lastPhase;
  logic             subDone;
  logic             topRun;
  logic             topDone;

  assign lastPhase = (subIdx == IDX_W'(SUB_PHASES - 1));
  assign subLimit  = lastPhase ? SUB_W'(SUB_LONG - 2) : SUB_W'(SUB_LONG - 1);
  assign subDone   = strobe.advance && (subCount == subLimit);
  assign topRun    = (strobe.divSel >= 3'd3);
  assign topLimit  = TOP_W'(topTerm(strobe.divSel, SUB_PHASES) - 1);
  assign topDone   = (topCount == topLimit);

  // Bottom stage: tick counter and sub-pulse phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCount <= '0;
      subIdx   <= '0;
    end else if (strobe.restart) begin
      subCount <= '0;
      subIdx   <= '0;
    end else if (strobe.advance) begin
      if (subDone) begin
        subCount <= '0;
        subIdx   <= lastPhase ? '0 : subIdx + 1'b1;
      end else begin
        subCount <= subCount + 1'b1;
      end
    end
  end

  // Top stage: counts sub-pulses, runs only for the longer intervals.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      topCount <= '0;
    else if (strobe.restart)
      topCount <= '0;
    else if (subDone && topRun)
      topCount <= topDone ? '0 : topCount + 1'b1;
  end

  always_comb begin
    case (strobe.divSel)
      3'd0:    intervalHit = 1'b0;
      3'd1:    intervalHit = subDone;
      3'd2:    intervalHit = subDone && subIdx[0];
      default: intervalHit = subDone && topDone;
    endcase
  end

endmodule

// File: rtl/rtc_interval_gen.sv
module rtc_interval_gen
  import rtc_pkg::*;
#(
  parameter int SUB_LONG   = 19,
  parameter int SUB_PHASES = 4,
  parameter int TOP_W      = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       tick,
  output logic [7:0] rdData,
  output logic       irqFlag,
  output logic       irqReq
);

  dpStrobe_t  strobe;
  logic       intervalHit;
  logic       enReg;
  logic [2:0] divReg;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tick(tick),
    .intervalHit(intervalHit), .strobe(strobe), .enReg(enReg),
    .divReg(divReg), .irqFlag(irqFlag), .irqReq(irqReq)
  );

  rtc_pulse_dp #(
    .SUB_LONG(SUB_LONG), .SUB_PHASES(SUB_PHASES), .TOP_W(TOP_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .intervalHit(intervalHit)
  );

  assign rdData = {irqFlag, enReg, 3'b000, divReg};

endmodule

// File: rtl/rtc_interval_gen_chk.sv
module rtc_interval_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       tick,
  input logic [7:0] rdData,
  input logic       irqFlag,
  input logic       irqReq
);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdData[5:3] == 3'b000);

  assert_mode0_silent_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($past(rdData[2:0]) != 3'd0));

  assert_flag_clear_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqFlag) |-> ($past(wrEn) && !$past(wrData[7])));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> irqFlag);

  assert_no_event_disabled_R9: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> ($past(rdData[6]) && $past(tick)));

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |=> !irqReq);

endmodule

bind rtc_interval_gen rtc_interval_gen_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tick(tick),
  .rdData(rdData), .irqFlag(irqFlag), .irqReq(irqReq)
);

// File: tb/test_rtc_interval_gen.sv
module test_rtc_interval_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       tick = 1'b0;
  logic [7:0] rdData;
  logic       irqFlag;
  logic       irqReq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench model state
  bit       mEn = 1'b0;
  bit [2:0] mDiv = 3'd0;
  bit       mFlag = 1'b0;
  int       mCnt = 0;

  always #2 clk = ~clk;

  rtc_interval_gen i_rtc_interval_gen (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .tick(tick),
    .rdData(rdData), .irqFlag(irqFlag), .irqReq(irqReq)
  );

  function automatic int unitsOf(input bit [2:0] sel);
    case (sel)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 4;
      3'd4: return 8;
      3'd5: return 10;
      3'd6: return 20;
      3'd7: return 50;
      default: return 0;
    endcase
  endfunction

  // k-th event lands on tick ceil(k*U*75/4): true when a multiple falls in (t-1, t].
  function automatic bit eventAt(input bit [2:0] sel, input int t);
    int u = unitsOf(sel);
    if (u == 0) return 1'b0;
    return ((4 * t) / (75 * u)) != ((4 * (t - 1)) / (75 * u));
  endfunction

  function automatic string modeTag(input bit [2:0] sel);
    case (sel)
      3'd0: return "R6";
      3'd1: return "R3";
      3'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle: drive, update the model, then compare after the edge.
  task automatic step(input bit wr, input bit [7:0] d, input bit tk);
    bit restart;
    bit adv;
    bit hit;
    @(negedge clk);
    wrEn = wr; wrData = d; tick = tk;
    restart = wr && (d[5] || (d[2:0] != mDiv));
    adv = tk && mEn && !restart;
    hit = 1'b0;
    if (adv) begin
      mCnt++;
      hit = eventAt(mDiv, mCnt);
    end
    if (restart) mCnt = 0;
    if (hit) mFlag = 1'b1;
    else if (wr && !d[7]) mFlag = 1'b0;
    if (wr) begin
      mEn = d[6];
      mDiv = d[2:0];
    end
    @(posedge clk);
    #1;
    wrEn = 1'b0; tick = 1'b0;
    check(irqReq == hit, {modeTag(mDiv), " R12 irqReq"}, irqReq, hit);
    check(irqFlag == mFlag, "R7 irqFlag", irqFlag, mFlag);
    check(rdData == {mFlag, mEn, 3'b000, mDiv}, "R2 rdData", rdData,
          {mFlag, mEn, 3'b000, mDiv});
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    int seen;
    int got;
    bit [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check(rdData == 8'h00, "R1 rdData", rdData, 0);
    check(irqFlag == 1'b0 && irqReq == 1'b0, "R1 outputs", {irqFlag, irqReq}, 0);

    // R2: reserved bits ignore writes; clear bit reads 0
    step(1'b1, 8'b0011_1101, 1'b0);
    check(rdData == 8'h05, "R2 readback", rdData, 8'h05);

    // R3 R4 R5: long constant runs in every mode
    for (int m = 1; m < 8; m++) begin
      step(1'b1, {2'b01, 3'b000, 3'(m)}, 1'b0);
      seen = 0;
      for (int i = 0; i < 2000; i++) begin
        step(1'b0, 8'h00, 1'b1);
        if (irqReq) seen++;
      end
      check(seen >= 2, {modeTag(3'(m)), " event count"}, seen, 2);
    end

    // R6: select 0 silent
    step(1'b1, 8'h40, 1'b0);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      step(1'b0, 8'h00, 1'b1);
      if (irqReq) seen++;
    end
    check(seen == 0, "R6 no events", seen, 0);

    // R8: clearing write on the completing tick, same select
    step(1'b1, 8'h41, 1'b0);
    idleTicks(18);
    step(1'b1, 8'h41, 1'b1);
    check(irqFlag == 1'b1, "R8 set wins", irqFlag, 1);
    // R7: writing 1 to bit 7 keeps flag, writing 0 clears
    step(1'b1, 8'hC1, 1'b0);
    check(irqFlag == 1'b1, "R7 keep", irqFlag, 1);
    step(1'b1, 8'h41, 1'b0);
    check(irqFlag == 1'b0, "R7 clear", irqFlag, 0);

    // R9: pause and resume mid-interval in select 3
    step(1'b1, 8'h43, 1'b0);
    idleTicks(40);
    step(1'b1, 8'h03, 1'b0);
    idleTicks(100);
    step(1'b1, 8'h43, 1'b0);
    idleTicks(34);
    step(1'b0, 8'h00, 1'b1);
    check(irqReq == 1'b1, "R9 resume hit", irqReq, 1);

    // R10: restart command drops progress
    step(1'b1, 8'h41, 1'b0);
    step(1'b1, 8'h42, 1'b0);
    idleTicks(10);
    step(1'b1, 8'h62, 1'b1);
    got = 0;
    for (int i = 1; i <= 38; i++) begin
      step(1'b0, 8'h00, 1'b1);
      if (irqReq && got == 0) got = i;
    end
    check(got == 38, "R10 restart interval", got, 38);

    // R11: same select keeps position, new select restarts
    idleTicks(20);
    step(1'b1, 8'h02, 1'b0);
    step(1'b1, 8'h42, 1'b0);
    idleTicks(16);
    step(1'b0, 8'h00, 1'b1);
    check(irqReq == 1'b1, "R11 same select kept", irqReq, 1);
    idleTicks(5);
    step(1'b1, 8'h41, 1'b0);
    got = 0;
    for (int i = 1; i <= 19; i++) begin
      step(1'b0, 8'h00, 1'b1);
      if (irqReq && got == 0) got = i;
    end
    check(got == 19, "R11 new select restarts", got, 19);

    // Random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 30000; i++) begin
      d = 8'($urandom);
      if (($urandom % 100) < 80) d[6] = 1'b1;
      if (($urandom % 100) < 80) d[5] = 1'b0;
      step(($urandom % 300) == 0, d, ($urandom % 100) < 60);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule